// File: doc/BRIEF.md
# Cascadable Eight-Line Priority Interrupt Controller

This block collects eight interrupt request lines, ranks them by fixed priority and raises a single interrupt output towards the processor. When the processor answers with a one-cycle acknowledge pulse, the controller returns an 8-bit vector one clock later. It records the granted line as in service until an end-of-interrupt command clears it. Auto end-of-interrupt mode skips that record altogether. Software reaches the block through a two-address byte port. Address 0 is the command port and address 1 is the data port. An ordered run of initialization words configures the block, and later command writes handle end-of-interrupt and the choice of register read back.

Two copies can be chained. A master has a slave's interrupt output wired to one of its request lines. When the master acknowledges such a line, it drives the line number onto a 3-bit cascade bus and returns no vector itself. The slave whose programmed identity matches the bus supplies the vector. A build parameter selects the role of each copy. Requests are edge-triggered: a rising edge latches the request, and the request must still be high when the acknowledge arrives.

Top module: `pic_ctrl`

## Requirements
- R1: After reset, the interrupt output is low, and the request, in-service and mask registers all read 0. Data-port writes have no effect until a command byte with bit 4 set begins initialization.
- R2: A command byte with bit 4 set clears the mask and in-service registers and starts initialization. Its bit 1 set means single (no cascade) and bit 0 set means a fourth word follows. The following data-port writes are then taken in order as word two, word three (skipped when single) and word four (skipped when bit 0 is clear). After the sequence, data-port writes load the mask.
- R3: The vector for line n is word two bits [7:3] followed by n in bits [2:0].
- R4: A mask bit at 1 keeps its line from raising the interrupt output. The pending request still shows in the request register. The mask reads back on the data port.
- R5: Line 0 has the highest priority. The interrupt output is high only when an unmasked pending line has higher priority than every in-service line.
- R6: An acknowledge pulse causes `vec_valid` to rise for one cycle on the next clock with the vector. It also sets the granted line's in-service bit and clears its request bit.
- R7: When word four bit 1 is set (auto end-of-interrupt), an acknowledge leaves the in-service register unchanged.
- R8: Command byte 0x60+n clears in-service bit n. Command byte 0x20 clears the highest-priority in-service bit.
- R9: After command byte 0x0B, command-port reads return the in-service register. After 0x0A they return the request register, which is also the selection after initialization starts.
- R10: An acknowledge that arrives when no line can be granted returns the vector for line 7 and sets no in-service bit. This holds even while line 7 is masked.
- R11: A rising edge latches a request. The request drops if its line falls before the acknowledge. A line held high after its acknowledge does not request again.
- R12: On a master, word three is the mask of lines that have slaves. Acknowledging such a line drives `cas_oe` together with the line number on `cas_out`, and the master returns no vector. A slave takes word three bits [2:0] as its identity and answers an acknowledge only when `cas_in` matches it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 = command port, 1 = data port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected port |
| irq_in | input | 8 | Interrupt request lines |
| int_out | output | 1 | Interrupt towards the processor |
| ack_in | input | 1 | One-cycle acknowledge pulse |
| cas_in | input | 3 | Cascade bus as seen by a slave |
| cas_out | output | 3 | Cascade line number driven by a master |
| cas_oe | output | 1 | Master is driving the cascade bus |
| vec_out | output | 8 | Returned vector |
| vec_valid | output | 1 | Vector is valid this cycle |

## Verification
The bench builds two copies, one with `IS_SLAVE` = 0 and one with `IS_SLAVE` = 1. The slave's interrupt output feeds master line 2, and the master's cascade bus feeds the slave. This setup exercises the cascade handover, including the two-cycle path from a slave request to the master output, and it checks that exactly one copy returns each vector. The master is also re-initialized in single mode with auto end-of-interrupt, which shows that word three is skipped and covers a second vector base.

// File: rtl/pic_pkg.sv
package pic_pkg;

    localparam int unsigned LINES  = 8;
    localparam int unsigned IDX_W  = $clog2(LINES);
    localparam int unsigned DW     = 8;
    localparam int unsigned BASE_W = DW - IDX_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_W2,
        ST_W3,
        ST_W4,
        ST_RUN
    } seq_t;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [LINES-1:0]  slaves;
        logic [IDX_W-1:0]  my_id;
        logic              single;
        logic              want_w4;
        logic              aeoi;
    } cfg_t;

    typedef struct packed {
        logic             vld;
        logic [IDX_W-1:0] idx;
    } pick_t;

    // Lowest set index wins (line 0 is the highest priority).
    function automatic pick_t pick_first(input logic [LINES-1:0] v);
        pick_t r;
        r = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (v[i]) begin
                r.vld = 1'b1;
                r.idx = IDX_W'(i);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/pic_cfg.sv
module pic_cfg
    import pic_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             addr,
    input  logic [DW-1:0]    wdata,
    output cfg_t             cfg,
    output logic [LINES-1:0] mask,
    output logic             run,
    output logic             show_isr,
    output logic             start,
    output logic             eoi_spec,
    output logic             eoi_ns,
    output logic [IDX_W-1:0] eoi_idx
);

    seq_t st;
    logic cmd_wr, dat_wr, ocw_wr;

    assign cmd_wr   = wr_en && !addr;
    assign dat_wr   = wr_en && addr;
    assign start    = cmd_wr && wdata[4];
    assign ocw_wr   = cmd_wr && !wdata[4] && run;
    assign run      = (st == ST_RUN);
    assign eoi_spec = ocw_wr && !wdata[3] && (wdata[7:5] == 3'b011);
    assign eoi_ns   = ocw_wr && !wdata[3] && (wdata[7:5] == 3'b001);
    assign eoi_idx  = wdata[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_IDLE;
            cfg      <= '0;
            mask     <= '0;
            show_isr <= 1'b0;
        end else if (start) begin
            st          <= ST_W2;
            cfg.single  <= wdata[1];
            cfg.want_w4 <= wdata[0];
            cfg.aeoi    <= 1'b0;
            mask        <= '0;
            show_isr    <= 1'b0;
        end else if (cmd_wr && !wdata[4] && wdata[3] && wdata[1]) begin
            show_isr <= wdata[0];
        end else if (dat_wr) begin
            case (st)
                ST_W2: begin
                    cfg.base <= wdata[DW-1:IDX_W];
                    if (!cfg.single)     st <= ST_W3;
                    else if (cfg.want_w4) st <= ST_W4;
                    else                  st <= ST_RUN;
                end
                ST_W3: begin
                    cfg.slaves <= wdata[LINES-1:0];
                    cfg.my_id  <= wdata[IDX_W-1:0];
                    st         <= cfg.want_w4 ? ST_W4 : ST_RUN;
                end
                ST_W4: begin
                    cfg.aeoi <= wdata[1];
                    st       <= ST_RUN;
                end
                ST_RUN:  mask <= wdata[LINES-1:0];
                default: ;
            endcase
        end
    end

    p_seq_w3_r2: assert property (@(posedge clk) disable iff (rst)
        (dat_wr && !start && st == ST_W2 && !cfg.single) |=> (st == ST_W3));

    p_mask_load_r4: assert property (@(posedge clk) disable iff (rst)
        (dat_wr && !start && st == ST_RUN) |=> (mask == $past(wdata[LINES-1:0])));

    p_idle_holds_r1: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && !start) |=> (st == ST_IDLE && mask == '0));

endmodule

// File: rtl/pic_arb.sv
module pic_arb
    import pic_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              aeoi,
    input  logic              clr_all,
    input  logic [LINES-1:0]  irq_in,
    input  logic [LINES-1:0]  mask,
    input  logic              eoi_spec,
    input  logic [IDX_W-1:0]  eoi_idx,
    input  logic              eoi_ns,
    input  logic              ack,
    input  logic              no_vec,
    input  logic [BASE_W-1:0] base,
    output logic [LINES-1:0]  irr,
    output logic [LINES-1:0]  isr,
    output pick_t             grant,
    output logic              int_req,
    output logic [DW-1:0]     vec,
    output logic              vec_valid
);

    logic [LINES-1:0] irq_q, irr_n, isr_n;
    pick_t            req_top, isr_top;
    logic             ack_ok;

    always_comb begin
        req_top = pick_first(irr & ~mask);
        isr_top = pick_first(isr);
        grant   = req_top;
        if (isr_top.vld && req_top.idx >= isr_top.idx)
            grant.vld = 1'b0;
    end

    assign int_req = run && grant.vld;
    assign ack_ok  = ack && run;

    always_comb begin
        irr_n = (irr | (irq_in & ~irq_q)) & irq_in;
        isr_n = isr;
        if (eoi_spec)
            isr_n[eoi_idx] = 1'b0;
        if (eoi_ns && isr_top.vld)
            isr_n[isr_top.idx] = 1'b0;
        if (ack_ok && grant.vld) begin
            irr_n[grant.idx] = 1'b0;
            if (!aeoi)
                isr_n[grant.idx] = 1'b1;
        end
        if (clr_all) begin
            irr_n = '0;
            isr_n = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q     <= '0;
            irr       <= '0;
            isr       <= '0;
            vec       <= '0;
            vec_valid <= 1'b0;
        end else begin
            irq_q     <= irq_in;
            irr       <= irr_n;
            isr       <= isr_n;
            vec_valid <= ack_ok && !(grant.vld && no_vec);
            vec       <= grant.vld ? {base, grant.idx} : {base, IDX_W'(LINES - 1)};
        end
    end

    p_vec_after_ack_r6: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> $past(ack_ok));

    p_isr_set_r6: assert property (@(posedge clk) disable iff (rst)
        (ack_ok && grant.vld && !aeoi && !clr_all) |=> isr[$past(grant.idx)]);

    p_aeoi_keep_r7: assert property (@(posedge clk) disable iff (rst)
        (ack_ok && aeoi && !eoi_spec && !eoi_ns && !clr_all) |=> $stable(isr));

    p_spur_keep_r10: assert property (@(posedge clk) disable iff (rst)
        (ack_ok && !grant.vld && !eoi_spec && !eoi_ns && !clr_all) |=> $stable(isr));

endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl
    import pic_pkg::*;
#(
    parameter bit IS_SLAVE = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_wr,
    input  logic             bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic [LINES-1:0] irq_in,
    output logic             int_out,
    input  logic             ack_in,
    input  logic [IDX_W-1:0] cas_in,
    output logic [IDX_W-1:0] cas_out,
    output logic             cas_oe,
    output logic [DW-1:0]    vec_out,
    output logic             vec_valid
);

    cfg_t             cfg;
    logic [LINES-1:0] mask, irr, isr;
    logic             run, show_isr, start, eoi_spec, eoi_ns;
    logic [IDX_W-1:0] eoi_idx;
    pick_t            grant;
    logic             ack_sel, to_slave;

    pic_cfg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .cfg      (cfg),
        .mask     (mask),
        .run      (run),
        .show_isr (show_isr),
        .start    (start),
        .eoi_spec (eoi_spec),
        .eoi_ns   (eoi_ns),
        .eoi_idx  (eoi_idx)
    );

    // A slave answers only when the cascade bus names it.
    assign ack_sel  = ack_in && (!IS_SLAVE || cfg.single || (cas_in == cfg.my_id));
    assign to_slave = !IS_SLAVE && !cfg.single && grant.vld && cfg.slaves[grant.idx];

    pic_arb u_arb (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .aeoi      (cfg.aeoi),
        .clr_all   (start),
        .irq_in    (irq_in),
        .mask      (mask),
        .eoi_spec  (eoi_spec),
        .eoi_idx   (eoi_idx),
        .eoi_ns    (eoi_ns),
        .ack       (ack_sel),
        .no_vec    (to_slave),
        .base      (cfg.base),
        .irr       (irr),
        .isr       (isr),
        .grant     (grant),
        .int_req   (int_out),
        .vec       (vec_out),
        .vec_valid (vec_valid)
    );

    generate
        if (IS_SLAVE) begin : g_slave
            assign cas_out = '0;
            assign cas_oe  = 1'b0;
        end else begin : g_master
            assign cas_out = grant.idx;
            assign cas_oe  = ack_in && run && to_slave;
        end
    endgenerate

    assign bus_rdata = bus_addr ? DW'(mask) : (show_isr ? DW'(isr) : DW'(irr));

    p_cas_novec_r12: assert property (@(posedge clk) disable iff (rst)
        cas_oe |=> !vec_valid);

endmodule

// File: tb/pic_ctrl_test.sv
module pic_ctrl_test;
    import pic_pkg::*;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       m_wr = 1'b0, s_wr = 1'b0, bus_addr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] m_rdata, s_rdata;
    logic [7:0] m_ext = '0, s_irq = '0;
    logic       m_int, s_int, ack = 1'b0;
    logic [2:0] m_cas, s_cas;
    logic       m_cas_oe, s_cas_oe;
    logic [7:0] m_vec, s_vec;
    logic       m_vv, s_vv;
    logic [7:0] m_irq;

    int errors = 0;
    int checks = 0;
    logic [7:0] exp_q[$];

    always #10 clk = ~clk;

    assign m_irq = {m_ext[7:3], s_int, m_ext[1:0]};

    pic_ctrl #(.IS_SLAVE(1'b0)) uut (
        .clk(clk), .rst(rst), .bus_wr(m_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(m_rdata), .irq_in(m_irq), .int_out(m_int), .ack_in(ack),
        .cas_in(3'b000), .cas_out(m_cas), .cas_oe(m_cas_oe), .vec_out(m_vec), .vec_valid(m_vv)
    );

    pic_ctrl #(.IS_SLAVE(1'b1)) u_slave (
        .clk(clk), .rst(rst), .bus_wr(s_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(s_rdata), .irq_in(s_irq), .int_out(s_int), .ack_in(ack),
        .cas_in(m_cas), .cas_out(s_cas), .cas_oe(s_cas_oe), .vec_out(s_vec), .vec_valid(s_vv)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input bit slave, input bit a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d;
        if (slave) s_wr = 1'b1; else m_wr = 1'b1;
        @(negedge clk);
        m_wr = 1'b0; s_wr = 1'b0;
    endtask

    task automatic rd(input bit slave, input bit a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = slave ? s_rdata : m_rdata;
    endtask

    task automatic acknowledge(input logic [7:0] v);
        @(negedge clk);
        exp_q.push_back(v);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    // Scoreboard monitor: exactly one controller returns each expected vector.
    always @(negedge clk) begin
        if (!rst && (m_vv || s_vv)) begin
            if (m_vv && s_vv) check("R12 single responder", 8'h1, 8'h0);
            else if (exp_q.size() == 0) check("R6 unexpected vector", m_vv ? m_vec : s_vec, 8'hxx);
            else check("R6 vector", m_vv ? m_vec : s_vec, exp_q.pop_front());
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        summary();
    end

    initial begin
        logic [7:0] d;
        tick(3);
        rst = 1'b0;
        tick(1);

        // R1 reset state and writes ignored before initialization
        check("R1 int_out", {7'b0, m_int}, 8'h00);
        rd(0, 0, d); check("R1 irr", d, 8'h00);
        wr(0, 1, 8'h55);
        rd(0, 1, d); check("R1 mask ignored", d, 8'h00);

        // R2 initialization sequences
        wr(0, 0, 8'h11); wr(0, 1, 8'h20); wr(0, 1, 8'h04); wr(0, 1, 8'h01);
        wr(1, 0, 8'h11); wr(1, 1, 8'h28); wr(1, 1, 8'h02); wr(1, 1, 8'h01);
        wr(0, 1, 8'hF0);
        rd(0, 1, d); check("R2 data port is mask", d, 8'hF0);
        wr(0, 1, 8'h00); wr(1, 1, 8'h00);

        // R5 R6 R9 R3 basic request and acknowledge
        m_ext[5] = 1'b1; tick(1);
        check("R5 int_out", {7'b0, m_int}, 8'h01);
        acknowledge(8'h25);
        wr(0, 0, 8'h0B);
        rd(0, 0, d); check("R6 R9 isr after ack", d, 8'h20);
        m_ext[6] = 1'b1; tick(1);
        check("R5 lower prio blocked", {7'b0, m_int}, 8'h00);
        m_ext[3] = 1'b1; tick(1);
        check("R5 higher prio granted", {7'b0, m_int}, 8'h01);
        acknowledge(8'h23);
        rd(0, 0, d); check("R6 nested isr", d, 8'h28);
        // R8 non-specific then specific end of interrupt
        wr(0, 0, 8'h20);
        rd(0, 0, d); check("R8 non-specific eoi", d, 8'h20);
        check("R5 still blocked", {7'b0, m_int}, 8'h00);
        wr(0, 0, 8'h65);
        rd(0, 0, d); check("R8 specific eoi", d, 8'h00);
        check("R5 line 6 now granted", {7'b0, m_int}, 8'h01);
        acknowledge(8'h26);
        wr(0, 0, 8'h66);
        // R11 held levels do not request again; R9 request read-back
        wr(0, 0, 8'h0A);
        rd(0, 0, d); check("R11 R9 irr with held lines", d, 8'h00);
        check("R11 no re-request", {7'b0, m_int}, 8'h00);
        m_ext = '0; tick(1);

        // R4 masking
        wr(0, 1, 8'h02);
        m_ext[1] = 1'b1; tick(1);
        check("R4 masked line quiet", {7'b0, m_int}, 8'h00);
        rd(0, 0, d); check("R4 pending while masked", d, 8'h02);
        wr(0, 1, 8'h00);
        check("R4 unmasked line raises", {7'b0, m_int}, 8'h01);
        acknowledge(8'h21);
        wr(0, 0, 8'h61);
        m_ext = '0; tick(1);

        // R10 R11 spurious acknowledge with line 7 masked
        wr(0, 1, 8'h80);
        m_ext[4] = 1'b1; tick(1);
        check("R11 edge latched", {7'b0, m_int}, 8'h01);
        m_ext[4] = 1'b0; tick(1);
        check("R11 dropped request", {7'b0, m_int}, 8'h00);
        acknowledge(8'h27);
        wr(0, 0, 8'h0B);
        rd(0, 0, d); check("R10 no isr set", d, 8'h00);
        wr(0, 1, 8'h00);

        // R12 cascade through the slave on master line 2
        s_irq[1] = 1'b1; tick(2);
        check("R12 master sees slave", {7'b0, m_int}, 8'h01);
        @(negedge clk);
        exp_q.push_back(8'h29);
        ack = 1'b1;
        #2 check("R12 cas_oe", {7'b0, m_cas_oe}, 8'h01);
        check("R12 cas_out", {5'b0, m_cas}, 8'h02);
        @(negedge clk);
        ack = 1'b0;
        rd(0, 0, d); check("R12 master isr cascade", d, 8'h04);
        wr(1, 0, 8'h61); wr(0, 0, 8'h62);
        rd(0, 0, d); check("R12 master isr cleared", d, 8'h00);
        s_irq = '0; tick(1);

        // R2 R7 R3 single mode, skip of word three, auto end of interrupt
        wr(0, 0, 8'h13); wr(0, 1, 8'h48); wr(0, 1, 8'h03); wr(0, 1, 8'h00);
        rd(0, 1, d); check("R2 single mode reaches mask", d, 8'h00);
        m_ext[0] = 1'b1; tick(1);
        acknowledge(8'h48);
        wr(0, 0, 8'h0B);
        rd(0, 0, d); check("R7 auto eoi leaves isr", d, 8'h00);
        m_ext = '0;
        tick(3);
        check("R6 scoreboard drained", 8'(exp_q.size()), 8'h00);
        summary();
    end

endmodule